// File: doc/BRIEF.md
# Iterative Accumulate-Multiply Loop Engine

This block runs a fixed conditional loop in hardware as a small looping state machine around a datapath. A start strobe loads three registers: the running sum is cleared, an operand register captures the input `x_in`, and the accumulator is set to one. The state machine then tests the accumulator against a fixed threshold. While the accumulator is below that threshold, each pass adds the operand into the sum in one cycle. In the next cycle it multiplies the accumulator by the sum just formed.

The adder and the multiplier each take exactly one clock cycle. A comparator flag, examined in a dedicated test state, decides between another pass and the exit. A zero operand collapses the accumulator to zero, so the loop could otherwise run forever. A pass counter therefore stops the loop at a fixed cap and raises an error flag. The block pulses `done` for one cycle when it leaves the loop. The final sum, accumulator and pass count stay on the outputs until the next start.

Top module: `loop_engine`

## Requirements
- R1: During and after synchronous reset (`rst` high), `done`, `err`, `sum_out`, `acc_out` and `iter_out` are all zero and the engine is idle.
- R2: A start strobe seen while idle loads sum = 0, operand = `x_in`, accumulator = 1 and pass count = 0. The first threshold test happens two clock edges after the edge that sampled `start`.
- R3: Each pass takes three cycles (test, add, multiply). The add performs sum <- sum + operand. The multiply performs accumulator <- accumulator * (new sum). For a run of n passes, `done` is high in the cycle after the (3n+3)-th rising edge, counting the edge that sampled `start` as the first.
- R4: The loop leaves as soon as the accumulator is not below LIMIT (default 100000). `done` is then high for exactly one cycle with `err` low, and `sum_out` and `acc_out` do not change in that cycle.
- R5: When the true product does not fit in AW bits, the accumulator saturates to all ones.
- R6: When the pass count has reached MAX_ITER (default 1024) and the accumulator is still below LIMIT, the loop stops. `err` is set, `iter_out` equals MAX_ITER, and `done` still pulses once.
- R7: A start strobe while a run is in progress has no effect on the run's timing or results.
- R8: `iter_out` counts completed passes. It only holds, increments by one, or clears on a new start, and it never exceeds MAX_ITER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, acted on only when idle |
| x_in | input | XW (16) | Operand loaded at start |
| done | output | 1 | One-cycle pulse on loop exit |
| err | output | 1 | Pass cap hit before threshold |
| sum_out | output | XW+CW (27) | Final running sum |
| acc_out | output | AW (64) | Final accumulator |
| iter_out | output | CW (11) | Number of passes performed |

## Verification
The bench builds two copies side by side. The first uses the default 64-bit accumulator and a threshold of 100000. The second uses a 12-bit accumulator and a threshold of 4000, so a large operand drives the product past the register width and the saturation path is exercised. Both copies run every operand from 0 to 50, including the zero case that ends on the pass cap with the error flag. They also run a set of random large operands and a run that receives a second start strobe while busy. Exit latency, the single-cycle `done` pulse, and the final sum, accumulator, pass count and error flag are compared with a behavioural model on each run.

// File: rtl/loop_engine.sv
module loop_engine #(
  parameter int XW       = 16,
  parameter int AW       = 64,
  parameter int LIMIT    = 100000,
  parameter int MAX_ITER = 1024,
  localparam int CW      = $clog2(MAX_ITER + 1),
  localparam int SW      = XW + CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [XW-1:0] x_in,
  output logic          done,
  output logic          err,
  output logic [SW-1:0] sum_out,
  output logic [AW-1:0] acc_out,
  output logic [CW-1:0] iter_out
);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_TEST, S_ADD, S_MUL, S_FIN} state_t;

  localparam logic [AW-1:0] LIM = AW'(LIMIT);
  localparam logic [CW-1:0] CAP = CW'(MAX_ITER);

  state_t          st;
  logic [XW-1:0]   opnd;
  logic [SW-1:0]   sum;
  logic [AW-1:0]   acc;
  logic [CW-1:0]   iters;
  logic [AW+SW-1:0] prod;
  logic [AW-1:0]   acc_next;
  logic            lt, at_cap;

  assign lt       = acc < LIM;
  assign at_cap   = iters == CAP;
  assign prod     = {{SW{1'b0}}, acc} * {{AW{1'b0}}, sum};
  assign acc_next = (|prod[AW+SW-1:AW]) ? {AW{1'b1}} : prod[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      opnd  <= '0;
      sum   <= '0;
      acc   <= '0;
      iters <= '0;
      err   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) st <= S_INIT;
        S_INIT: begin
          sum   <= '0;
          opnd  <= x_in;
          acc   <= AW'(1);
          iters <= '0;
          err   <= 1'b0;
          st    <= S_TEST;
        end
        S_TEST: begin
          if (!lt) st <= S_FIN;
          else if (at_cap) begin
            err <= 1'b1;
            st  <= S_FIN;
          end else st <= S_ADD;
        end
        S_ADD: begin
          sum <= sum + SW'(opnd);
          st  <= S_MUL;
        end
        S_MUL: begin
          acc   <= acc_next;
          iters <= iters + 1'b1;
          st    <= S_TEST;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done     = st == S_FIN;
  assign sum_out  = sum;
  assign acc_out  = acc;
  assign iter_out = iters;

endmodule

// File: rtl/loop_engine_chk.sv
module loop_engine_chk #(
  parameter int AW       = 64,
  parameter int SW       = 27,
  parameter int CW       = 11,
  parameter int LIMIT    = 100000,
  parameter int MAX_ITER = 1024
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          err,
  input logic [SW-1:0] sum_out,
  input logic [AW-1:0] acc_out,
  input logic [CW-1:0] iter_out
);
  localparam logic [AW-1:0] LIM = AW'(LIMIT);
  localparam logic [CW-1:0] CAP = CW'(MAX_ITER);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) done |-> ($stable(acc_out) && $stable(sum_out))); // R4
  AST_EXIT_ABOVE: assert property (@(posedge clk) disable iff (rst) (done && !err) |-> (acc_out >= LIM)); // R4
  AST_ERR_CAP: assert property (@(posedge clk) disable iff (rst) (done && err) |-> (iter_out == CAP)); // R6
  AST_ITER_STEP: assert property (@(posedge clk) disable iff (rst) (iter_out == $past(iter_out)) || (iter_out == CW'($past(iter_out) + 1'b1)) || (iter_out == '0)); // R8
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst) iter_out <= CAP); // R8
endmodule

bind loop_engine loop_engine_chk #(
  .AW(AW), .SW(SW), .CW(CW), .LIMIT(LIMIT), .MAX_ITER(MAX_ITER)
) u_chk (
  .clk(clk), .rst(rst), .done(done), .err(err),
  .sum_out(sum_out), .acc_out(acc_out), .iter_out(iter_out)
);

// File: tb/test_loop_engine.sv
module test_loop_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] x = '0;

  logic        a_done, a_err, b_done, b_err;
  logic [26:0] a_sum, b_sum;
  logic [63:0] a_acc;
  logic [11:0] b_acc;
  logic [10:0] a_it, b_it;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  loop_engine i_loop_engine (
    .clk(clk), .rst(rst), .start(start), .x_in(x),
    .done(a_done), .err(a_err), .sum_out(a_sum), .acc_out(a_acc), .iter_out(a_it)
  );

  loop_engine #(.AW(12), .LIMIT(4000)) i_loop_engine_small (
    .clk(clk), .rst(rst), .start(start), .x_in(x),
    .done(b_done), .err(b_err), .sum_out(b_sum), .acc_out(b_acc), .iter_out(b_it)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input int xv, input int aw, input longint lim,
                       output logic [127:0] s, output logic [127:0] a, output int n, output bit e);
    logic [127:0] maxv;
    maxv = (128'd1 << aw) - 1;
    s = 0; a = 1; n = 0; e = 0;
    while (a < lim) begin
      if (n == 1024) begin e = 1; break; end
      s = s + xv;
      a = a * s;
      if (a > maxv) a = maxv;
      n++;
    end
  endtask

  task automatic run(input int xv, input bit poke);
    logic [127:0] es_a, ea_a, es_b, ea_b;
    int en_a, en_b, lat_a, lat_b, pulses_a, pulses_b, cyc;
    bit ee_a, ee_b;
    model(xv, 64, 100000, es_a, ea_a, en_a, ee_a);
    model(xv, 12, 4000, es_b, ea_b, en_b, ee_b);
    lat_a = 0; lat_b = 0; pulses_a = 0; pulses_b = 0;
    @(negedge clk); x = 16'(xv); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    forever begin
      if (poke && cyc == 4) begin start = 1'b1; x = 16'(xv + 7); end
      if (poke && cyc == 5) start = 1'b0;
      if (a_done) begin pulses_a++; if (lat_a == 0) lat_a = cyc; end
      if (b_done) begin pulses_b++; if (lat_b == 0) lat_b = cyc; end
      if (lat_a != 0 && lat_b != 0 && cyc > lat_a + 1 && cyc > lat_b + 1) break;
      if (cyc > 5000) begin
        check(1'b0, "watchdog", 128'(cyc), 128'(3 * 1024 + 3));
        break;
      end
      @(negedge clk); cyc++;
    end
    check(lat_a == 3 * en_a + 3, "R3 latency", 128'(lat_a), 128'(3 * en_a + 3));
    check(lat_b == 3 * en_b + 3, "R3 latency small", 128'(lat_b), 128'(3 * en_b + 3));
    check(pulses_a == 1 && pulses_b == 1, "R4 single done pulse", 128'(pulses_a + pulses_b), 128'd2);
    check(a_sum == es_a[26:0], "R3 sum", 128'(a_sum), es_a);
    check(128'(a_acc) == ea_a, "R3 acc", 128'(a_acc), ea_a);
    check(int'(a_it) == en_a, "R8 iterations", 128'(a_it), 128'(en_a));
    check(a_err == ee_a, ee_a ? "R6 err" : "R4 err", 128'(a_err), 128'(ee_a));
    check(b_sum == es_b[26:0], "R3 sum small", 128'(b_sum), es_b);
    check(128'(b_acc) == ea_b, "R5 acc small", 128'(b_acc), ea_b);
    check(int'(b_it) == en_b, "R8 iterations small", 128'(b_it), 128'(en_b));
    check(b_err == ee_b, ee_b ? "R6 err small" : "R4 err small", 128'(b_err), 128'(ee_b));
    if (poke) check(1'b1 && !a_done && !b_done, "R7 no restart", 128'(a_done | b_done), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!a_done && !a_err && a_sum == 0 && a_acc == 0 && a_it == 0, "R1 reset",
          128'({a_done, a_err, a_sum, a_it}) | 128'(a_acc), 128'd0);
    check(!b_done && !b_err && b_sum == 0 && b_acc == 0 && b_it == 0, "R1 reset small",
          128'({b_done, b_err, b_sum, b_acc, b_it}), 128'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!a_done && !b_done, "R1 idle after reset", 128'(a_done | b_done), 128'd0);
    // R2 and R3: operands 0 to 50; operand 0 reaches the pass cap (R6)
    for (int v = 0; v <= 50; v++) run(v, 1'b0);
    // R5: large operands saturate the small accumulator
    run(65535, 1'b0);
    for (int k = 0; k < 8; k++) run(int'($urandom_range(51, 65535)), 1'b0);
    // R7: second start while busy
    run(1, 1'b1);
    run(3, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule